// File: doc/BRIEF.md
# Digit-Serial Dual Constant Multiplier (29x and 43x)

This block multiplies one unsigned input word by the two fixed constants 29 and 43 at the same time. It works in digit-serial form. Each clock cycle it takes one digit of `DIGIT_W` bits of the input, least significant digit first, and it returns the matching digit of both products in that same cycle. The datapath is built only from digit-serial full-adder chains, one two's-complement subtractor and delay lines that perform the left shifts. Its size therefore depends on the digit width and on the shift amounts, and not on the word length.

Both products share one partial product. The block first forms 7x as (x shifted left by 3) minus x. It then forms 29x as (7x shifted left by 2) plus x, and 43x as 29x plus (7x shifted left by 1). A shift is not free in this form. A left shift by `ls` costs `ls` flip-flops in total, spread over the bit lanes of a digit. Each adder and the subtractor holds one carry flip-flop between digits.

A word strobe marks the first digit of every word. In that cycle every carry and every delay stage is treated as being in its fresh state, so words can follow each other with no gap. A new strobe also abandons a word that has not finished. A word of `WORD_W` bits takes `ceil((WORD_W+6)/DIGIT_W)` digit cycles, which leaves room for the six bits of growth that multiplying by 43 needs. The block flags the digit cycles of a word and marks the last one.

Top module: `dsm_mcm29_43`

## Requirements
- R1: Digit k of a word (k = 0 first) carries input bits [k*DIGIT_W +: DIGIT_W], with bit 0 of a digit as its least significant bit. Product digit k appears on the outputs combinationally in the same cycle as input digit k.
- R2: Over the digit cycles of one word, `p29_dig_o` delivers the digits of 29·x, least significant first.
- R3: Over the digit cycles of one word, `p43_dig_o` delivers the digits of 43·x, least significant first.
- R4: `start_i` high together with digit 0 makes every adder carry 0, the subtractor carry 1 and every shift delay stage 0 for that digit. The result does not depend on any earlier word, and this holds also when the earlier word was cut short or ended in the previous cycle.
- R5: A word spans NDIG = ceil((WORD_W+6)/DIGIT_W) digit cycles. The digits fed after bit WORD_W-1 are zero, and all NDIG·DIGIT_W product bits are exact, including for the all-ones input.
- R6: `valid_o` is high in the cycle `start_i` is asserted and in the NDIG-1 cycles after it, unless a new strobe comes first. `last_o` is high only in the final one of those cycles. Both are low otherwise.
- R7: After reset, with no strobe and zero input digits, `valid_o`, `last_o` and both product digits are 0. They stay 0 between complete words when the input digit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Marks digit 0 of a new word; clears the carry and shift state for that digit |
| x_dig_i | input | DIGIT_W | Current input digit, least significant digit of the word first |
| p29_dig_o | output | DIGIT_W | Current digit of 29·x |
| p43_dig_o | output | DIGIT_W | Current digit of 43·x |
| valid_o | output | 1 | High during the digit cycles of a word |
| last_o | output | 1 | High on the final digit cycle of a word |

## Verification
The assertions assume that `start_i` comes with digit 0 of each word, and that any digit of the word before a strobe has already been consumed. The delay-line check also assumes that the input digit is stable in the cycle it is captured. The product checks in the first-digit cycle rely on the zero state that the strobe forces. The stimulus pads each word with zero digits above bit WORD_W-1. It leaves the input digit at zero in idle cycles, and it starts a new word only with a strobe. Some words are abandoned early on purpose, and the next strobe always follows them at once.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

   // Bits of growth needed so that 43*x fits (43 < 2**6).
   localparam int GROWTH_BITS = 6;

   // Digit cycles that cover a word plus the product growth.
   function automatic int digits_per_word(input int word_w, input int dig_w);
      return (word_w + GROWTH_BITS + dig_w - 1) / dig_w;
   endfunction

   // Whole-digit delay that output lane `lane` of a left shift by `ls` needs.
   function automatic int shl_delay(input int lane, input int ls, input int dig_w);
      if (lane >= ls) return 0;
      return (ls - lane + dig_w - 1) / dig_w;
   endfunction

   // Input lane that feeds output lane `lane` of a left shift by `ls`.
   function automatic int shl_src(input int lane, input int ls, input int dig_w);
      if (lane >= ls) return lane - ls;
      return shl_delay(lane, ls, dig_w) * dig_w - (ls - lane);
   endfunction

endpackage

// File: rtl/dsm_shl.sv
// Digit-serial left shift: one delay line per bit lane, ls flops in total.
module dsm_shl #(
   parameter int DIGIT_W = 2,
   parameter int SHIFT   = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [DIGIT_W-1:0] d_i,
   output logic [DIGIT_W-1:0] d_o
);

   if (DIGIT_W < 1) begin : g_bad_width
      $error("dsm_shl: DIGIT_W must be at least 1");
   end
   if (SHIFT < 0) begin : g_bad_shift
      $error("dsm_shl: SHIFT must not be negative");
   end

   // Becomes 1 one clock after reset ends; lets the delay check use $past safely.
   logic armed_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= 1'b1;
   end

   for (genvar gi = 0; gi < DIGIT_W; gi++) begin : g_lane
      localparam int DLY = dsm_pkg::shl_delay(gi, SHIFT, DIGIT_W);
      localparam int SRC = dsm_pkg::shl_src(gi, SHIFT, DIGIT_W);

      if (DLY == 0) begin : g_wire
         assign d_o[gi] = d_i[SRC];
      end else begin : g_delay
         logic [DLY-1:0] sr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sr_q <= '0;
            end else begin
               sr_q[0] <= d_i[SRC];
               for (int m = 1; m < DLY; m++) begin
                  sr_q[m] <= start_i ? 1'b0 : sr_q[m-1];
               end
            end
         end
         // A new word sees only zeros shifted in from below its bit 0.
         assign d_o[gi] = start_i ? 1'b0 : sr_q[DLY-1];

         if (DLY == 1) begin : g_chk
            p_lane_delay_r1 : assert property (@(posedge clk) disable iff (!rst_n)
               (armed_q && !start_i) |-> (d_o[gi] == $past(d_i[SRC])))
               else $error("shift lane %0d lost its one-digit delay", gi);
         end
         p_lane_fresh_r4 : assert property (@(posedge clk) disable iff (!rst_n)
            start_i |-> (d_o[gi] == 1'b0))
            else $error("shift lane %0d leaked state into a new word", gi);
      end
   end

endmodule

// File: rtl/dsm_addsub.sv
// Digit-serial adder or two's-complement subtractor: full-adder chain plus one carry flop.
module dsm_addsub #(
   parameter int DIGIT_W  = 2,
   parameter bit SUBTRACT = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [DIGIT_W-1:0] a_i,
   input  logic [DIGIT_W-1:0] b_i,
   output logic [DIGIT_W-1:0] s_o
);

   if (DIGIT_W < 1) begin : g_bad_width
      $error("dsm_addsub: DIGIT_W must be at least 1");
   end

   localparam logic CARRY_INIT = SUBTRACT;

   logic [DIGIT_W-1:0] b_op;
   logic [DIGIT_W:0]   c;
   logic               carry_q;

   if (SUBTRACT) begin : g_inv
      assign b_op = ~b_i;
   end else begin : g_pass
      assign b_op = b_i;
   end

   assign c[0] = start_i ? CARRY_INIT : carry_q;

   for (genvar gi = 0; gi < DIGIT_W; gi++) begin : g_fa
      assign s_o[gi]   = a_i[gi] ^ b_op[gi] ^ c[gi];
      assign c[gi+1]   = (a_i[gi] & b_op[gi]) | (a_i[gi] & c[gi]) | (b_op[gi] & c[gi]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) carry_q <= CARRY_INIT;
      else        carry_q <= c[DIGIT_W];
   end

   if (SUBTRACT) begin : g_sub_chk
      p_sub_fresh_r4 : assert property (@(posedge clk) disable iff (!rst_n)
         start_i |-> (s_o == DIGIT_W'(a_i - b_i)))
         else $error("subtractor used stale borrow on first digit");
      p_sub_noborrow_r4 : assert property (@(posedge clk) disable iff (!rst_n)
         (start_i && (b_i == '0)) |=> c[0])
         else $error("subtractor borrowed after subtracting zero");
   end else begin : g_add_chk
      p_add_fresh_r4 : assert property (@(posedge clk) disable iff (!rst_n)
         start_i |-> (s_o == DIGIT_W'(a_i + b_i)))
         else $error("adder used stale carry on first digit");
      p_add_nocarry_r4 : assert property (@(posedge clk) disable iff (!rst_n)
         (start_i && (a_i == '0) && (b_i == '0)) |=> (!c[0] || start_i))
         else $error("adder carried after adding zeros");
   end

endmodule

// File: rtl/dsm_digit_ctr.sv
// Tracks the digit position inside a word; saturates at NDIG when idle.
module dsm_digit_ctr #(
   parameter int NDIG = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic valid_o,
   output logic last_o
);

   if (NDIG < 1) begin : g_bad_ndig
      $error("dsm_digit_ctr: NDIG must be at least 1");
   end

   localparam int CW = $clog2(NDIG + 1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] idx;

   assign idx     = start_i ? '0 : cnt_q;
   assign valid_o = (idx < CW'(NDIG));
   assign last_o  = (idx == CW'(NDIG - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= CW'(NDIG);
      else if (valid_o) cnt_q <= idx + 1'b1;
      else              cnt_q <= CW'(NDIG);
   end

   p_start_valid_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> valid_o)
      else $error("strobe cycle not flagged valid");
   p_last_then_idle_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      last_o |=> (!valid_o || start_i))
      else $error("word ran past its last digit");
   p_last_in_word_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o)
      else $error("last digit flagged outside a word");

endmodule

// File: rtl/dsm_mcm29_43.sv
// Shared-term digit-serial multiplier: 7x = 8x - x, 29x = 4*7x + x, 43x = 29x + 2*7x.
module dsm_mcm29_43 #(
   parameter int DIGIT_W = 2,
   parameter int WORD_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [DIGIT_W-1:0] x_dig_i,
   output logic [DIGIT_W-1:0] p29_dig_o,
   output logic [DIGIT_W-1:0] p43_dig_o,
   output logic               valid_o,
   output logic               last_o
);

   if (DIGIT_W < 1) begin : g_bad_digit
      $error("dsm_mcm29_43: DIGIT_W must be at least 1");
   end
   if (WORD_W < 1) begin : g_bad_word
      $error("dsm_mcm29_43: WORD_W must be at least 1");
   end

   localparam int NDIG = dsm_pkg::digits_per_word(WORD_W, DIGIT_W);

   logic [DIGIT_W-1:0] x8_dig, t7_dig, t28_dig, t14_dig, t29_dig, t43_dig;

   dsm_shl #(.DIGIT_W(DIGIT_W), .SHIFT(3)) u_shl_x8 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .d_i(x_dig_i), .d_o(x8_dig));

   dsm_addsub #(.DIGIT_W(DIGIT_W), .SUBTRACT(1'b1)) u_sub_t7 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .a_i(x8_dig), .b_i(x_dig_i), .s_o(t7_dig));

   dsm_shl #(.DIGIT_W(DIGIT_W), .SHIFT(2)) u_shl_t28 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .d_i(t7_dig), .d_o(t28_dig));

   dsm_shl #(.DIGIT_W(DIGIT_W), .SHIFT(1)) u_shl_t14 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .d_i(t7_dig), .d_o(t14_dig));

   dsm_addsub #(.DIGIT_W(DIGIT_W), .SUBTRACT(1'b0)) u_add_t29 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .a_i(t28_dig), .b_i(x_dig_i), .s_o(t29_dig));

   dsm_addsub #(.DIGIT_W(DIGIT_W), .SUBTRACT(1'b0)) u_add_t43 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .a_i(t29_dig), .b_i(t14_dig), .s_o(t43_dig));

   dsm_digit_ctr #(.NDIG(NDIG)) u_ctr (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_o(valid_o), .last_o(last_o));

   assign p29_dig_o = t29_dig;
   assign p43_dig_o = t43_dig;

   p_first_digit29_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> (p29_dig_o == DIGIT_W'(int'(x_dig_i) * 29)))
      else $error("first digit of 29x wrong");
   p_first_digit43_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> (p43_dig_o == DIGIT_W'(int'(x_dig_i) * 43)))
      else $error("first digit of 43x wrong");

endmodule

// File: tb/dsm_mcm29_43_tb_top.sv
module dsm_mcm29_43_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int DW   = 2;
   localparam int WW   = 8;
   localparam int NDIG = (WW + 6 + DW - 1) / DW;
   localparam int MASK = (1 << DW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [DW-1:0] xd = '0;
   logic [DW-1:0] p29, p43;
   logic          vld, lst;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dsm_mcm29_43 #(.DIGIT_W(DW), .WORD_W(WW)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .x_dig_i(xd),
      .p29_dig_o(p29), .p43_dig_o(p43), .valid_o(vld), .last_o(lst));

   task automatic cmp(input string req, input string scen, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s (%s) actual=%0d expected=%0d", req, scen, act, exp);
      end
   endtask

   // Drive one digit at the falling edge, compare just after it.
   task automatic step(input bit st, input int dig, input int e29, input int e43,
                       input bit ev, input bit el, input string scen);
      @(negedge clk);
      start = st;
      xd    = DW'(dig);
      #1;
      cmp("R2", scen, int'(p29), e29);
      cmp("R3", scen, int'(p43), e43);
      cmp("R6 valid", scen, int'(vld), int'(ev));
      cmp("R6 last", scen, int'(lst), int'(el));
   endtask

   // Reference: digit k of the product is (x*c >> k*DW) & MASK.
   task automatic send_word(input int x, input int ndrive, input string scen);
      for (int k = 0; k < ndrive; k++) begin
         step(k == 0, (x >> (DW*k)) & MASK,
              ((x*29) >> (DW*k)) & MASK, ((x*43) >> (DW*k)) & MASK,
              1'b1, k == NDIG-1, scen);
      end
   endtask

   task automatic idle(input int n, input string scen);
      for (int i = 0; i < n; i++) step(1'b0, 0, 0, 0, 1'b0, 1'b0, scen);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      // R7: state during and right after reset
      repeat (2) @(posedge clk);
      step(1'b0, 0, 0, 0, 1'b0, 1'b0, "R7 in reset");
      @(negedge clk);
      rst_n = 1'b1;
      idle(2, "R7 after reset");

      // R1: simple patterns checking digit ordering
      send_word(0, NDIG, "R1 zero");
      send_word(1, NDIG, "R1 one");
      idle(2, "R7 idle gap");
      send_word(8'h4B, NDIG, "R1 mixed");
      idle(1, "R7 idle gap");

      // R5: full-scale input, all growth bits used
      send_word(255, NDIG, "R5 max");
      idle(1, "R7 idle gap");

      // R4: back-to-back words without a gap
      send_word(170, NDIG, "R4 b2b 0xAA");
      send_word(85,  NDIG, "R4 b2b 0x55");
      send_word(255, NDIG, "R4 b2b max");
      send_word(255, NDIG, "R4 b2b max again");
      send_word(2,   NDIG, "R4 b2b after max");

      // R4: abandoned words followed at once by a new strobe
      send_word(255, 3, "R4 abort long");
      send_word(3, NDIG, "R4 after abort");
      send_word(255, 1, "R4 abort short");
      send_word(0, NDIG, "R4 zero after abort");
      idle(2, "R7 idle gap");

      // R2/R3: random words with random gaps
      for (int w = 0; w < 40; w++) begin
         send_word(int'($urandom_range(0, 255)), NDIG, "R2 R3 random");
         idle(int'($urandom_range(0, 2)), "R7 random gap");
      end
      idle(3, "R7 tail");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule